// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block pairs a 16-bit up-counter with one 16-bit capture/compare register. The counter advances while its run enable is high. It wraps from its top value to zero with a one-cycle overflow pulse, and a synchronous clear forces it back to zero. A single mode input decides the register's role.

In compare mode the register holds a threshold. A one-cycle match interrupt fires when the live count first equals that threshold. A threshold of zero therefore fires each time the counter restarts from zero. In capture mode the register snapshots the count when a qualifying edge arrives on an asynchronous trigger pin. The pin is first synchronized by two flops, and a 2-bit edge-select field picks which transitions qualify.

Software-style writes to the register always land while the counter is stopped. While it is running, they land only when the pulse-generator mode flag is set. The stored value is always visible on a combinational read port.

Top module: `tmr_ccu`

## Requirements
- R1: After synchronous reset, the count, the stored register value, the overflow pulse and the match interrupt are all zero.
- R2: The count rises by one on each clock with run high and holds with run low. A clr pulse sets the count to zero on the next edge and overrides run.
- R3: When the count at 0xFFFF advances, it becomes 0x0000 and ovf is high for exactly the one cycle in which the count reads 0x0000.
- R4: With mode low (compare), match_irq is high for exactly one cycle: the first cycle in which the count equals the stored value. It does not stay high on later cycles.
- R5: A stored value of 0x0000 in compare mode makes match_irq fire when the count returns to zero after a wrap or after a clr. It does not fire in the first cycle after reset.
- R6: With mode high (capture) and edge_sel = 2'b01, a rising transition on trig_in captures and a falling one does not.
- R7: With edge_sel = 2'b00, only falling transitions on trig_in capture.
- R8: With edge_sel = 2'b11, both rising and falling transitions capture.
- R9: With edge_sel = 2'b10, which is the prohibited code, no transition captures.
- R10: If trig_in changes just before clock edge k, the register stores the count value present in the cycle before edge k+3, and rd_data shows it from edge k+3.
- R11: A write (wr_en with wr_data) takes effect on the next edge if run is low or pgen_mode is high. Otherwise it is ignored.
- R12: When a capture and an accepted write fall on the same edge, the capture wins. rd_data always follows the stored value combinationally.
- R13: In capture mode match_irq stays low, even when the count passes the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Counter run enable |
| clr | input | 1 | Synchronous counter clear |
| mode | input | 1 | 0 = compare, 1 = capture |
| edge_sel | input | 2 | Capture edge: 00 fall, 01 rise, 11 both, 10 prohibited |
| pgen_mode | input | 1 | Allows writes while the counter runs |
| trig_in | input | 1 | Asynchronous capture trigger pin |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Stored register value |
| count | output | 16 | Live counter value |
| ovf | output | 1 | Wrap pulse |
| match_irq | output | 1 | Compare match interrupt pulse |

## Verification
The results arrive at different delays, and each check is tied to its own delay. Counter changes and accepted writes show one edge after the inputs. The match interrupt and the overflow pulse appear in the same cycle as the count value that causes them. A pin transition reaches the stored register on the third edge after it is first sampled. Inputs are driven on the falling clock edge. The capture task reads the count at the third falling edge after it moves the pin and reads rd_data at the fourth, which matches the three-register path exactly.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W = 16;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_RSVD = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef enum logic {
        MODE_CMP = 1'b0,
        MODE_CAP = 1'b1
    } cc_mode_e;

    function automatic logic edge_hit(edge_sel_e sel, logic rise, logic fall);
        case (sel)
            EDGE_FALL: return fall;
            EDGE_RISE: return rise;
            EDGE_BOTH: return rise | fall;
            default:   return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = tmr_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         clr,
    output logic [W-1:0] count,
    output logic         ovf
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            ovf <= 1'b0;
            if (clr) begin
                count <= '0;
            end else if (run) begin
                count <= count + 1'b1;
                ovf   <= (count == TOP);
            end
        end
    end

    // R3
    ovf_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (count == '0));
    // R2
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0));
endmodule

// File: rtl/tmr_edge_det.sv
module tmr_edge_det
    import tmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pin,
    input  edge_sel_e edge_sel,
    output logic      hit_q
);
    logic s1, s2, s3;
    logic hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
            hit_q <= 1'b0;
        end else begin
            s1 <= pin;
            s2 <= s1;
            s3 <= s2;
            hit_q <= hit;
        end
    end

    always_comb hit = edge_hit(edge_sel, s2 & ~s3, ~s2 & s3);

    // R9
    rsvd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_sel == EDGE_RSVD) |=> !hit_q);
endmodule

// File: rtl/tmr_ccreg.sv
module tmr_ccreg
    import tmr_pkg::*;
#(
    parameter int W = tmr_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  cc_mode_e     mode,
    input  logic         run,
    input  logic         pgen_mode,
    input  logic         trig_hit,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] count,
    output logic [W-1:0] cc_val,
    output logic         match_irq
);
    logic eq, eq_d, cap_fire, wr_ok;

    always_comb begin
        eq        = (count == cc_val);
        cap_fire  = trig_hit && (mode == MODE_CAP);
        wr_ok     = wr_en && (!run || pgen_mode);
        match_irq = (mode == MODE_CMP) && eq && !eq_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cc_val <= '0;
            eq_d   <= 1'b1;
        end else begin
            eq_d <= eq;
            if (cap_fire)
                cc_val <= count;
            else if (wr_ok)
                cc_val <= wr_data;
        end
    end

    // R10
    cap_store_chk: assert property (@(posedge clk) disable iff (rst)
        cap_fire |=> (cc_val == $past(count)));
    // R11
    wr_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && run && !pgen_mode && !cap_fire) |=> (cc_val == $past(cc_val)));
    // R4
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        match_irq |=> !match_irq);
endmodule

// File: rtl/tmr_ccu.sv
module tmr_ccu
    import tmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        run,
    input  logic        clr,
    input  logic        mode,
    input  logic [1:0]  edge_sel,
    input  logic        pgen_mode,
    input  logic        trig_in,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    output logic [15:0] count,
    output logic        ovf,
    output logic        match_irq
);
    localparam int W = CNT_W;

    logic     trig_hit;
    cc_mode_e mode_e;
    edge_sel_e sel_e;

    assign mode_e = cc_mode_e'(mode);
    assign sel_e  = edge_sel_e'(edge_sel);

    tmr_counter #(.W(W)) u_cnt (
        .clk(clk), .rst(rst), .run(run), .clr(clr),
        .count(count), .ovf(ovf)
    );

    tmr_edge_det u_edge (
        .clk(clk), .rst(rst), .pin(trig_in), .edge_sel(sel_e), .hit_q(trig_hit)
    );

    tmr_ccreg #(.W(W)) u_reg (
        .clk(clk), .rst(rst), .mode(mode_e), .run(run), .pgen_mode(pgen_mode),
        .trig_hit(trig_hit), .wr_en(wr_en), .wr_data(wr_data), .count(count),
        .cc_val(rd_data), .match_irq(match_irq)
    );

    // R5
    zero_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf && !mode && rd_data == '0) |-> match_irq);
endmodule

// File: tb/sim_tmr_ccu.sv
module sim_tmr_ccu;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run = 1'b0, clr = 1'b0, mode = 1'b0, pgen_mode = 1'b0;
    logic trig_in = 1'b0, wr_en = 1'b0;
    logic [1:0] edge_sel = 2'b01;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data, count;
    logic ovf, match_irq;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    typedef struct { string req; logic [15:0] val; } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    tmr_ccu u0 (
        .clk(clk), .rst(rst), .run(run), .clr(clr), .mode(mode),
        .edge_sel(edge_sel), .pgen_mode(pgen_mode), .trig_in(trig_in),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .count(count),
        .ovf(ovf), .match_irq(match_irq)
    );

    // driver side: queue the expected item
    task automatic push_exp(string req, logic [15:0] v);
        exp_t e;
        e.req = req; e.val = v;
        exp_q.push_back(e);
    endtask

    // monitor side: pop and compare with what the design shows
    task automatic mon_cmp(logic [15:0] act);
        exp_t e;
        e = exp_q.pop_front();
        n_chk++;
        if (act !== e.val) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", e.req, act, e.val);
        end
    endtask

    task automatic chk(string req, logic [15:0] act, logic [15:0] v);
        push_exp(req, v);
        mon_cmp(act);
    endtask

    task automatic wr_reg(logic [15:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // move the pin, then verify capture (or no capture) four falling edges later
    task automatic cap_edge(string req, logic lvl, bit expect_cap);
        logic [15:0] old_v, snap;
        old_v = rd_data;
        trig_in = lvl;
        repeat (3) @(negedge clk);
        snap = count;
        @(negedge clk);
        chk(req, rd_data, expect_cap ? snap : old_v);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] snap;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 count", count, 16'h0000);
        chk("R1 reg", rd_data, 16'h0000);
        chk("R1 irq", {15'b0, match_irq}, 16'h0);
        chk("R1 ovf", {15'b0, ovf}, 16'h0);

        // R11 write while stopped
        wr_reg(16'h0005);
        chk("R11 write stopped", rd_data, 16'h0005);

        // R2 / R4 run and compare match at 5
        run = 1'b1;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            chk("R2 count", count, 16'(i));
            chk("R4 irq", {15'b0, match_irq}, {15'b0, (i == 5)});
        end

        // R11 ignored while running without pgen_mode
        wr_reg(16'h1234);
        chk("R11 ignored", rd_data, 16'h0005);
        pgen_mode = 1'b1;
        wr_reg(16'h0009);
        chk("R11 pgen write", rd_data, 16'h0009);
        pgen_mode = 1'b0;

        // R2 hold and clear
        run = 1'b0;
        @(negedge clk);
        snap = count;
        repeat (3) @(negedge clk);
        chk("R2 hold", count, snap);
        run = 1'b1; clr = 1'b1;
        @(negedge clk);
        clr = 1'b0; run = 1'b0;
        chk("R2 clr", count, 16'h0000);

        // R5 zero compare after clear
        run = 1'b1;
        repeat (4) @(negedge clk);
        run = 1'b0;
        wr_reg(16'h0000);
        chk("R5 no irq before restart", {15'b0, match_irq}, 16'h0);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk("R5 irq after clr", {15'b0, match_irq}, 16'h1);

        // R3 / R5 wrap
        run = 1'b1;
        repeat (65535) @(negedge clk);
        chk("R3 top", count, 16'hFFFF);
        chk("R3 no ovf yet", {15'b0, ovf}, 16'h0);
        @(negedge clk);
        chk("R3 wrap", count, 16'h0000);
        chk("R3 ovf", {15'b0, ovf}, 16'h1);
        chk("R5 irq after wrap", {15'b0, match_irq}, 16'h1);
        @(negedge clk);
        chk("R3 ovf one cycle", {15'b0, ovf}, 16'h0);
        chk("R4 irq one cycle", {15'b0, match_irq}, 16'h0);

        // R13 no irq in capture mode
        run = 1'b0;
        wr_reg(16'h0005);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0; mode = 1'b1; run = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R13 irq low", {15'b0, match_irq}, 16'h0);
        end

        // R6 / R10 rising
        edge_sel = 2'b01;
        @(negedge clk);
        cap_edge("R6 R10 rise", 1'b1, 1'b1);
        cap_edge("R6 fall ignored", 1'b0, 1'b0);
        // R7 falling
        edge_sel = 2'b00;
        @(negedge clk);
        cap_edge("R7 rise ignored", 1'b1, 1'b0);
        cap_edge("R7 fall", 1'b0, 1'b1);
        // R8 both
        edge_sel = 2'b11;
        @(negedge clk);
        cap_edge("R8 rise", 1'b1, 1'b1);
        cap_edge("R8 fall", 1'b0, 1'b1);
        // R9 prohibited code
        edge_sel = 2'b10;
        @(negedge clk);
        cap_edge("R9 rise", 1'b1, 1'b0);
        cap_edge("R9 fall", 1'b0, 1'b0);

        // R12 capture beats a same-edge write
        edge_sel = 2'b01;
        pgen_mode = 1'b1;
        @(negedge clk);
        trig_in = 1'b1;
        repeat (3) @(negedge clk);
        snap = count;
        wr_en = 1'b1; wr_data = 16'hBEEF;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R12 capture wins", rd_data, snap);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule